// File: doc/BRIEF.md
# Fractional Clock-Enable Divider with Half-Step Predivider

This block turns a stream of single-cycle input ticks into a slower stream of single-cycle output ticks. The ratio between the two streams is programmable and may be fractional. The input ticks are taken to run at twice the base rate, so a whole-number skip count can stand for division by half-integer steps of the base rate.

Two stages run in series. The first is a predivider that keeps one input tick out of every h+1. The second is an optional M/N accumulator that keeps M ticks out of every N predivided ticks. The accumulator also drives a level output, whose duty cycle is set by a threshold compare against the accumulator value.

Software programs N and the threshold in an inverted form, and the block decodes that form. Configuration inputs take effect only when an apply strobe is raised. The same strobe restarts both counting stages. A separate combinational helper computes the predivider setting that suits a given source rate and target rate.

Top module: `mnd_frac_div`

## Requirements
- R1: After reset the outputs `tick_o` and `duty_o` are low. The active configuration is all zero, so each input tick gives an output tick one cycle later.
- R2: With predivider setting h, counting restarts from zero at apply. Each (h+1)-th input tick after apply is passed on, and `tick_o` goes high in the cycle after that input tick. A setting of 0 passes every tick.
- R3: The effective N is (bitwise inverse of the 8-bit N field) + M, computed without wrapping (9-bit result).
- R4: When the M/N stage is active, each passed tick adds M to an accumulator that starts at 0. When the sum reaches N or more, N is subtracted and `tick_o` is raised in the next cycle. Any N consecutive passed ticks therefore yield exactly M output ticks, provided M < N.
- R5: The M/N stage is bypassed, and passed ticks go straight to `tick_o`, when any of these holds: the 2-bit mode field is 0, the effective N is 0, or the effective N equals M.
- R6: `duty_o` is high exactly when the M/N stage is active and the accumulator is below the threshold. The threshold is the bitwise inverse of the 8-bit D field. In bypass, `duty_o` is low.
- R7: In a cycle where `cfg_apply_i` is high, the accumulator and the predivider count are cleared, any input tick is ignored, and `tick_o` is low in the next cycle. The new configuration governs from the following cycle on.
- R8: `byte_div_o` = ceil(2 × `par_rate_i` / `tgt_rate_i`) − 1, clamped to 31. It is 31 when the target is 0, and 0 when the source rate is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_apply_i | input | 1 | Latch the configuration inputs and restart counting |
| prediv_i | input | 5 | Predivider setting h |
| mode_i | input | 2 | Nonzero enables the M/N stage |
| m_i | input | 8 | M value |
| nreg_i | input | 8 | Inverse of (N − M) |
| dreg_i | input | 8 | Inverse of the duty threshold |
| tick_i | input | 1 | Input tick at twice the base rate |
| par_rate_i | input | 12 | Source rate for the divider helper |
| tgt_rate_i | input | 12 | Target rate for the divider helper |
| byte_div_o | output | 5 | Suggested predivider setting |
| tick_o | output | 1 | Output tick |
| duty_o | output | 1 | Duty-cycle level |

## Verification
A wrong predivider count shows up as an output tick one input tick early or late. This becomes visible within h+1 input ticks of apply. A wrong accumulator value or a misdecoded N moves the output tick positions and changes the `duty_o` level within one passed tick. It also breaks the M-in-N count over a full window. The bench compares every cycle of each run against a model built from the requirements, so the first divergent cycle is reported.

// File: rtl/mnd_div_pkg.sv
package mnd_div_pkg;

    localparam int HID_W  = 5;
    localparam int MND_W  = 8;
    localparam int RATE_W = 12;
    localparam int ACC_W  = MND_W + 1;
    localparam int QUO_W  = RATE_W + 2;

    localparam logic [HID_W-1:0] HID_MAX = '1;

    typedef struct packed {
        logic [HID_W-1:0] prediv;
        logic [1:0]       mode;
        logic [MND_W-1:0] m;
        logic [MND_W-1:0] nreg;
        logic [MND_W-1:0] dreg;
    } mnd_cfg_t;

    // Effective N from the inverted (N - M) field.
    function automatic logic [ACC_W-1:0] decode_n(input logic [MND_W-1:0] m,
                                                  input logic [MND_W-1:0] nreg);
        return {1'b0, ~nreg} + {1'b0, m};
    endfunction

    function automatic logic [MND_W-1:0] decode_d(input logic [MND_W-1:0] dreg);
        return ~dreg;
    endfunction

    // ceil(2*par/tgt) - 1, clamped to the predivider field range.
    function automatic logic [HID_W-1:0] calc_byte_div(input logic [RATE_W-1:0] par,
                                                       input logic [RATE_W-1:0] tgt);
        logic [QUO_W-1:0] num;
        logic [QUO_W-1:0] quo;
        if (tgt == '0) return HID_MAX;
        num = {1'b0, par, 1'b0} + {2'b00, tgt} - QUO_W'(1);
        quo = num / {2'b00, tgt};
        if (quo == '0) return '0;
        if ((quo - QUO_W'(1)) > QUO_W'(HID_MAX)) return HID_MAX;
        return HID_W'(quo - QUO_W'(1));
    endfunction

endpackage

// File: rtl/mnd_cfg_latch.sv
module mnd_cfg_latch
    import mnd_div_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  apply,
    input  mnd_cfg_t              cfg_in,
    output mnd_cfg_t              cfg_q,
    output logic [ACC_W-1:0]      n_true,
    output logic [MND_W-1:0]      d_thr,
    output logic                  active
);
    always_ff @(posedge clk) begin
        if (rst)        cfg_q <= '0;
        else if (apply) cfg_q <= cfg_in;
    end

    always_comb begin
        n_true = decode_n(cfg_q.m, cfg_q.nreg);
        d_thr  = decode_d(cfg_q.dreg);
        active = (cfg_q.mode != 2'd0) && (n_true != '0) &&
                 (n_true != {1'b0, cfg_q.m});
    end
endmodule

// File: rtl/mnd_prediv.sv
module mnd_prediv
    import mnd_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             tick_i,
    input  logic [HID_W-1:0] prediv,
    output logic             pre_tick
);
    logic [HID_W-1:0] cnt_q;
    logic             at_end;

    assign at_end   = (cnt_q == prediv);
    assign pre_tick = tick_i && !restart && at_end;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= at_end ? '0 : cnt_q + HID_W'(1);
        end
    end
endmodule

// File: rtl/mnd_accum.sv
module mnd_accum
    import mnd_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             pre_tick,
    input  logic             active,
    input  logic [MND_W-1:0] m,
    input  logic [ACC_W-1:0] n_true,
    input  logic [MND_W-1:0] d_thr,
    output logic             tick_o,
    output logic             duty_o,
    output logic [ACC_W-1:0] acc_o
);
    logic [ACC_W:0] sum;
    logic           wrap;

    assign sum  = {1'b0, acc_o} + {2'b00, m};
    assign wrap = (sum >= {1'b0, n_true});

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            acc_o  <= '0;
            tick_o <= 1'b0;
        end else begin
            if (active) begin
                tick_o <= pre_tick && wrap;
                if (pre_tick) acc_o <= wrap ? ACC_W'(sum - {1'b0, n_true}) : ACC_W'(sum);
            end else begin
                tick_o <= pre_tick;
            end
        end
    end

    assign duty_o = active && (acc_o < {1'b0, d_thr});
endmodule

// File: rtl/mnd_frac_div.sv
module mnd_frac_div
    import mnd_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_apply_i,
    input  logic [HID_W-1:0]  prediv_i,
    input  logic [1:0]        mode_i,
    input  logic [MND_W-1:0]  m_i,
    input  logic [MND_W-1:0]  nreg_i,
    input  logic [MND_W-1:0]  dreg_i,
    input  logic              tick_i,
    input  logic [RATE_W-1:0] par_rate_i,
    input  logic [RATE_W-1:0] tgt_rate_i,
    output logic [HID_W-1:0]  byte_div_o,
    output logic              tick_o,
    output logic              duty_o
);
    mnd_cfg_t         cfg_in;
    mnd_cfg_t         cfg_q;
    logic [ACC_W-1:0] n_true;
    logic [MND_W-1:0] d_thr;
    logic             mn_active;
    logic             pre_tick;
    logic [ACC_W-1:0] acc_val;

    assign cfg_in = '{prediv: prediv_i, mode: mode_i, m: m_i, nreg: nreg_i, dreg: dreg_i};

    mnd_cfg_latch u_cfg (
        .clk    (clk),
        .rst    (rst),
        .apply  (cfg_apply_i),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q),
        .n_true (n_true),
        .d_thr  (d_thr),
        .active (mn_active)
    );

    mnd_prediv u_pre (
        .clk      (clk),
        .rst      (rst),
        .restart  (cfg_apply_i),
        .tick_i   (tick_i),
        .prediv   (cfg_q.prediv),
        .pre_tick (pre_tick)
    );

    mnd_accum u_acc (
        .clk      (clk),
        .rst      (rst),
        .restart  (cfg_apply_i),
        .pre_tick (pre_tick),
        .active   (mn_active),
        .m        (cfg_q.m),
        .n_true   (n_true),
        .d_thr    (d_thr),
        .tick_o   (tick_o),
        .duty_o   (duty_o),
        .acc_o    (acc_val)
    );

    assign byte_div_o = calc_byte_div(par_rate_i, tgt_rate_i);
endmodule

// File: rtl/mnd_frac_div_chk.sv
module mnd_frac_div_chk
    import mnd_div_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_apply_i,
    input logic              tick_i,
    input logic              tick_o,
    input logic              duty_o,
    input logic [RATE_W-1:0] par_rate_i,
    input logic [RATE_W-1:0] tgt_rate_i,
    input logic [HID_W-1:0]  byte_div_o,
    input logic              mn_active,
    input logic [MND_W-1:0]  m_q,
    input logic [ACC_W-1:0]  n_true,
    input logic [ACC_W-1:0]  acc_val
);
    logic [31:0] lo_prod;
    logic [31:0] hi_prod;
    logic [31:0] twice_par;
    assign lo_prod   = 32'(byte_div_o) * 32'(tgt_rate_i);
    assign hi_prod   = (32'(byte_div_o) + 32'd1) * 32'(tgt_rate_i);
    assign twice_par = 32'(par_rate_i) * 32'd2;

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!tick_o && !duty_o)); // R1
    AST_OUT_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        tick_o |-> $past(tick_i)); // R2
    AST_ACC_BOUND: assert property (@(posedge clk) disable iff (rst)
        (mn_active && ({1'b0, m_q} < n_true)) |-> (acc_val < n_true)); // R4
    AST_APPLY_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_apply_i) |-> !tick_o); // R7
    AST_DIV_COVERS: assert property (@(posedge clk) disable iff (rst)
        ((tgt_rate_i != '0) && (par_rate_i != '0)) |->
        ((hi_prod >= twice_par || byte_div_o == HID_MAX) &&
         (byte_div_o == '0 || lo_prod < twice_par))); // R8
endmodule

bind mnd_frac_div mnd_frac_div_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_apply_i (cfg_apply_i),
    .tick_i      (tick_i),
    .tick_o      (tick_o),
    .duty_o      (duty_o),
    .par_rate_i  (par_rate_i),
    .tgt_rate_i  (tgt_rate_i),
    .byte_div_o  (byte_div_o),
    .mn_active   (mn_active),
    .m_q         (cfg_q.m),
    .n_true      (n_true),
    .acc_val     (acc_val)
);

// File: tb/mnd_frac_div_tb.sv
module mnd_frac_div_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_apply_i;
    logic [4:0]  prediv_i;
    logic [1:0]  mode_i;
    logic [7:0]  m_i, nreg_i, dreg_i;
    logic        tick_i;
    logic [11:0] par_rate_i, tgt_rate_i;
    logic [4:0]  byte_div_o;
    logic        tick_o, duty_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    mnd_frac_div u_dut (
        .clk(clk), .rst(rst), .cfg_apply_i(cfg_apply_i), .prediv_i(prediv_i),
        .mode_i(mode_i), .m_i(m_i), .nreg_i(nreg_i), .dreg_i(dreg_i),
        .tick_i(tick_i), .par_rate_i(par_rate_i), .tgt_rate_i(tgt_rate_i),
        .byte_div_o(byte_div_o), .tick_o(tick_o), .duty_o(duty_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic t);
        tick_i = t;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Applies a configuration while an input tick is present (R7: it is ignored).
    task automatic apply(input int h, input int mode, input int m, input int n, input int thr);
        prediv_i = 5'(h); mode_i = 2'(mode); m_i = 8'(m);
        nreg_i = 8'(~(n - m)); dreg_i = 8'(~thr);
        cfg_apply_i = 1'b1;
        cyc(1'b1);
        cfg_apply_i = 1'b0;
        check(tick_o == 1'b0, "R7 tick low after apply", int'(tick_o), 0);
    endtask

    // Runs a tick pattern and compares every cycle to a model built from R2..R6.
    task automatic run(input int h, input int mode, input int m, input int n, input int thr,
                       input int cycles, input int gap, input string req);
        int  pc = 0;
        int  acc = 0;
        int  pulses = 0;
        int  passed = 0;
        bit  act = (mode != 0) && (n != 0) && (n != m);
        apply(h, mode, m, n, thr);
        for (int i = 0; i < cycles; i++) begin
            bit t = (gap == 0) || ((i % gap) != gap - 1);
            bit pre = 0;
            bit exp_t;
            bit exp_d;
            if (t) begin
                if (pc == h) begin pc = 0; pre = 1; end
                else pc++;
            end
            exp_t = pre;
            if (act) begin
                exp_t = 0;
                if (pre) begin
                    acc += m;
                    if (acc >= n) begin acc -= n; exp_t = 1; end
                end
            end
            exp_d = act && (acc < thr);
            if (pre) passed++;
            cyc(t);
            if (tick_o) pulses++;
            check(tick_o == exp_t, {req, " tick"}, int'(tick_o), int'(exp_t));
            check(duty_o == exp_d, "R6 duty", int'(duty_o), int'(exp_d));
        end
        if (act && (passed % n == 0))
            check(pulses == passed / n * m, "R4 M per N window", pulses, passed / n * m);
    endtask

    task automatic t_reset;
        check(tick_o == 1'b0, "R1 tick at reset", int'(tick_o), 0);
        check(duty_o == 1'b0, "R1 duty at reset", int'(duty_o), 0);
        rst = 1'b0;
        cyc(1'b1); check(tick_o == 1'b1, "R1 default pass", int'(tick_o), 1);
        cyc(1'b0); check(tick_o == 1'b0, "R1 default idle", int'(tick_o), 0);
        cyc(1'b1); check(tick_o == 1'b1, "R1 default pass", int'(tick_o), 1);
    endtask

    task automatic t_prediv;
        run(1, 0, 0, 0, 0, 12, 0, "R2 h=1");
        run(4, 0, 0, 0, 0, 25, 3, "R2 h=4 gaps");
        run(0, 0, 0, 0, 0, 6, 2, "R2 h=0");
    endtask

    task automatic t_mn;
        run(0, 2, 3, 8, 4, 32, 0, "R4 R3 m3 n8");
        run(2, 1, 2, 5, 3, 45, 3, "R4 R3 h2 m2 n5");
        run(0, 3, 7, 200, 100, 40, 0, "R3 large n");
    endtask

    task automatic t_bypass;
        run(1, 0, 3, 8, 4, 10, 0, "R5 mode0");
        run(0, 1, 5, 5, 9, 8, 0, "R5 n eq m");
        run(0, 1, 0, 0, 9, 8, 0, "R5 n zero");
    endtask

    task automatic t_restart;
        apply(3, 0, 0, 0, 0);
        cyc(1'b1); cyc(1'b1);
        apply(3, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) begin
            cyc(1'b1);
            check(tick_o == 1'b0, "R7 count restarted", int'(tick_o), 0);
        end
        cyc(1'b1);
        check(tick_o == 1'b1, "R7 fourth tick passes", int'(tick_o), 1);
    endtask

    task automatic div_case(input int p, input int t);
        int q;
        int e;
        par_rate_i = 12'(p); tgt_rate_i = 12'(t);
        #1;
        if (t == 0) e = 31;
        else begin
            q = (2 * p + t - 1) / t;
            e = (q == 0) ? 0 : ((q - 1 > 31) ? 31 : q - 1);
        end
        check(int'(byte_div_o) == e, "R8 byte divider", int'(byte_div_o), e);
    endtask

    task automatic t_byte_div;
        div_case(100, 30);
        div_case(100, 0);
        div_case(1000, 10);
        div_case(60, 40);
        div_case(0, 5);
        div_case(4095, 4095);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_apply_i = 1'b0; prediv_i = '0; mode_i = '0;
        m_i = '0; nreg_i = '0; dreg_i = '0; tick_i = 1'b0;
        par_rate_i = '0; tgt_rate_i = '0;
        repeat (3) @(negedge clk);
        t_reset;
        t_prediv;
        t_mn;
        t_bypass;
        t_restart;
        t_byte_div;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule